// File: doc/BRIEF.md
# Pipelined Floating-Point Adder-Subtractor

This block adds or subtracts two normalized binary floating-point numbers in four register-separated stages. It accepts a new operand pair on every clock and delivers one normalized result per clock, four cycles after the pair was accepted. Each operand carries a sign bit, a biased exponent field and a fraction field with an implied leading one. The exponent and fraction widths are parameters. The default is 8 exponent bits and 23 fraction bits.

The four stages run in a fixed order. The first stage compares the operands and keeps the larger exponent as the working exponent. The second stage shifts the smaller operand's mantissa right until it lines up with the larger one. The third stage adds or subtracts the two magnitudes. The fourth stage renormalizes the result and packs it into the output word.

Bits that fall off during alignment or normalization are discarded, so results are truncated. The block has no rounding, no infinities, no NaNs, no denormals and no exception flags. The caller must keep operand exponents far enough from the ends of the range that normalization never wraps the exponent field.

Top module: `fp_addsub_pipe`

## Requirements
- R1: The operand and result word is `{sign, exponent[EXP_W-1:0], fraction[FRAC_W-1:0]}`, with the sign in the most significant bit. The mantissa of an operand is the fraction with a leading one placed above it.
- R2: `out_valid` is high exactly four clock cycles after `in_valid` was high, and low four cycles after `in_valid` was low. While reset is held, `out_valid` and `result` are zero.
- R3: When `sub` is 0 the result is `op_a + op_b`. When `sub` is 1 the result is `op_a - op_b`, which is computed by inverting the sign of `op_b`.
- R4: The operand with the larger magnitude, compared as `{exponent, fraction}`, supplies the result sign and the starting exponent. On a tie, `op_a` counts as the larger operand. When the effective signs differ, the smaller magnitude is subtracted from the larger.
- R5: The smaller operand's mantissa is shifted right by the exponent difference, and any bits shifted out are discarded. If the difference is at least FRAC_W+1, the smaller operand contributes zero.
- R6: If the magnitude sum carries past the leading mantissa position, the mantissa is shifted right by one, the bit shifted out is discarded, and the exponent is incremented by one.
- R7: If the result has leading zeros, the mantissa is shifted left and the exponent is reduced by the same amount, until the leading mantissa bit is one.
- R8: An exact cancellation produces the all-zero word, with sign 0 and exponent 0.
- R9: One operand pair can be accepted on every cycle, and results leave in the same order that the pairs entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks that `op_a`, `op_b` and `sub` hold a pair to process |
| op_a | input | EXP_W+FRAC_W+1 | First operand |
| op_b | input | EXP_W+FRAC_W+1 | Second operand |
| sub | input | 1 | 1 selects subtraction, 0 selects addition |
| out_valid | output | 1 | Marks that `result` holds a finished value |
| result | output | EXP_W+FRAC_W+1 | Normalized, truncated sum or difference |

## Verification
The two functions most likely to fall in the same cycle are the acceptance of a fresh pair in stage one and the renormalization of an older pair in stage four. A mistake here shows up as a mixed-up or shifted result stream rather than as one bad value. The bench provokes this by streaming every combination of a small configuration (3 fraction bits, exponents 4 to 13, both signs, both operations) back to back, with an idle bubble inserted now and then. It judges each output cycle against an in-order queue of arithmetically computed results, and it checks the valid strobe on every cycle, including the bubble cycles.

// File: rtl/fp_addsub_pipe.sv
module fp_addsub_pipe #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W  = EXP_W + FRAC_W + 1,
  localparam int MW = FRAC_W + 1,
  localparam int SW = $clog2(MW + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub,
  output logic         out_valid,
  output logic [W-1:0] result
);

  // stage 1: compare
  logic             b_sign, a_big;
  logic [EXP_W-1:0] ea, eb;
  assign b_sign = op_b[W-1] ^ sub;
  assign a_big  = op_a[W-2:0] >= op_b[W-2:0];
  assign ea     = op_a[W-2:FRAC_W];
  assign eb     = op_b[W-2:FRAC_W];

  logic             v1, s1_sign, s1_sub;
  logic [EXP_W-1:0] s1_exp, s1_diff;
  logic [MW-1:0]    s1_mbig, s1_msml;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0; s1_sign <= 1'b0; s1_sub <= 1'b0;
      s1_exp <= '0; s1_diff <= '0; s1_mbig <= '0; s1_msml <= '0;
    end else begin
      v1      <= in_valid;
      s1_sign <= a_big ? op_a[W-1] : b_sign;
      s1_sub  <= op_a[W-1] != b_sign;
      s1_exp  <= a_big ? ea : eb;
      s1_diff <= a_big ? ea - eb : eb - ea;
      s1_mbig <= a_big ? {1'b1, op_a[FRAC_W-1:0]} : {1'b1, op_b[FRAC_W-1:0]};
      s1_msml <= a_big ? {1'b1, op_b[FRAC_W-1:0]} : {1'b1, op_a[FRAC_W-1:0]};
    end

  // stage 2: align
  logic [MW-1:0] aligned;
  assign aligned = (32'(s1_diff) >= MW) ? '0 : s1_msml >> s1_diff;

  logic             v2, s2_sign, s2_sub;
  logic [EXP_W-1:0] s2_exp;
  logic [MW-1:0]    s2_mbig, s2_msml;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v2 <= 1'b0; s2_sign <= 1'b0; s2_sub <= 1'b0;
      s2_exp <= '0; s2_mbig <= '0; s2_msml <= '0;
    end else begin
      v2 <= v1; s2_sign <= s1_sign; s2_sub <= s1_sub;
      s2_exp <= s1_exp; s2_mbig <= s1_mbig; s2_msml <= aligned;
    end

  // stage 3: add / subtract magnitudes
  logic             v3, s3_sign;
  logic [EXP_W-1:0] s3_exp;
  logic [MW:0]      s3_sum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v3 <= 1'b0; s3_sign <= 1'b0; s3_exp <= '0; s3_sum <= '0;
    end else begin
      v3 <= v2; s3_sign <= s2_sign; s3_exp <= s2_exp;
      s3_sum <= s2_sub ? {1'b0, s2_mbig} - {1'b0, s2_msml}
                       : {1'b0, s2_mbig} + {1'b0, s2_msml};
    end

  // stage 4: normalize
  logic [SW-1:0]    lz;
  logic [MW-1:0]    norm_m;
  logic [EXP_W-1:0] norm_e;

  always_comb begin
    lz = '0;
    for (int i = 0; i < MW; i++)
      if (s3_sum[i]) lz = SW'(MW - 1 - i);
    if (s3_sum[MW]) begin
      norm_m = s3_sum[MW:1];
      norm_e = s3_exp + 1'b1;
    end else begin
      norm_m = s3_sum[MW-1:0] << lz;
      norm_e = s3_exp - EXP_W'(lz);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; result <= '0;
    end else begin
      out_valid <= v3;
      result    <= (s3_sum == '0) ? '0 : {s3_sign, norm_e, norm_m[FRAC_W-1:0]};
    end

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 out_valid);
  a_r2_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##4 !out_valid);
  a_r5_aligned_not_larger: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> s2_msml <= s2_mbig);
  a_r4_sub_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && s2_sub) |=> !s3_sum[MW]);
  a_r8_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result[W-2:FRAC_W] == '0) |-> result == '0);

endmodule

// File: tb/tb_fp_addsub_pipe.sv
module tb_fp_addsub_pipe;
  localparam int EW = 4, FW = 3, W = EW + FW + 1, MW = FW + 1;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, sub = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic [W-1:0] result;

  fp_addsub_pipe #(.EXP_W(EW), .FRAC_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub(sub), .out_valid(out_valid), .result(result));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic         hv [4];
  logic [W-1:0] hr [4];
  logic [W-1:0] lastexp;

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b, logic s);
    int ma, mb, ea, eb, big_m, sml_m, e, d, r;
    logic sa, sb, sg;
    sa = a[W-1]; sb = b[W-1] ^ s;
    ea = int'(a[W-2:FW]); eb = int'(b[W-2:FW]);
    ma = int'(a[FW-1:0]) + (1 << FW); mb = int'(b[FW-1:0]) + (1 << FW);
    if (ea * 256 + ma >= eb * 256 + mb) begin
      sg = sa; e = ea; big_m = ma; sml_m = mb; d = ea - eb;
    end else begin
      sg = sb; e = eb; big_m = mb; sml_m = ma; d = eb - ea;
    end
    sml_m = (d >= MW) ? 0 : sml_m / (1 << d);
    r = (sa == sb) ? big_m + sml_m : big_m - sml_m;
    if (r == 0) return '0;
    while (r >= (1 << MW)) begin r = r / 2; e = e + 1; end
    while (r < (1 << FW)) begin r = r * 2; e = e - 1; end
    return {sg, EW'(e), FW'(r)};
  endfunction

  task automatic step(logic v, logic [W-1:0] a, logic [W-1:0] b, logic s);
    @(negedge clk);
    checks++;
    if (out_valid !== hv[3]) begin
      fails++;
      $display("FAIL R2/R9 out_valid actual %b expected %b", out_valid, hv[3]);
    end else if (hv[3] && result !== hr[3]) begin
      fails++;
      $display("FAIL R3-model (R4 R5 R6 R7 R8) result actual %h expected %h", result, hr[3]);
    end
    for (int k = 3; k > 0; k--) begin hv[k] = hv[k-1]; hr[k] = hr[k-1]; end
    hv[0] = v; hr[0] = v ? model(a, b, s) : '0;
    in_valid = v; op_a = a; op_b = b; sub = s;
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    for (int k = 0; k < 4; k++) begin hv[k] = 1'b0; hr[k] = '0; end
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R2 reset state actual %b/%h expected 0/0", out_valid, result);
    end
    rst_n = 1'b1;
    // R1 R3 R4 R5 R6 R7 R8 R9: exhaustive sweep of the small configuration
    n = 0;
    for (int xa = 0; xa < 160; xa++)
      for (int xb = 0; xb < 160; xb++)
        for (int s = 0; s < 2; s++) begin
          logic [W-1:0] a, b;
          a = {1'(xa % 2), EW'(4 + (xa / 16)), FW'((xa / 2) % 8)};
          b = {1'(xb % 2), EW'(4 + (xb / 16)), FW'((xb / 2) % 8)};
          n++;
          if (n % 13 == 0) step(1'b0, '0, '0, 1'b0);
          step(1'b1, a, b, 1'(s));
        end
    repeat (5) step(1'b0, '0, '0, 1'b0);
    // R8 directed: exact cancellation gives all-zero word
    lastexp = model(8'h5B, 8'h5B, 1'b1);
    checks++;
    if (lastexp !== '0) begin
      fails++;
      $display("FAIL R8 model cancel actual %h expected 00", lastexp);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule